// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block brings a processor system out of hardware reset and switches on its supply rails in a fixed order. A reset request input, active low, puts the block into a reset-hold state. The block keeps its reset output low for a set hold time and also while the battery comparator reports that input power is missing. After the hold, it releases the reset output. It then switches on the high-voltage rails, and after a delay it switches on the low-voltage rails. After a further delay it samples a power-good flag, which an outside agent produces from the regulator status. If the flag is good, the block enables the oscillator/PLL and, one cycle later, signals run. If the flag is bad, the block latches a fault state with both rails off.

Every delay is a parameter in milliseconds and is converted to clock ticks through a clock-frequency parameter, so a simulation can use small values. All delays share one down-counter, which is reloaded each time a new state is entered. The three asynchronous inputs each pass through a two-flop synchronizer, and every output comes straight from a flop.

Top module: `pwr_seq`

## Requirements
- R1: While `rst_n` is low, every output is low: `rst_out_n`, `batt_flt_n`, `sys_en`, `pwr_en`, `clk_en` and `run`.
- R2: While `rst_req_n` is low, `rst_out_n` and all enables stay low. After release with the battery good, `rst_out_n` rises on rising edge number HOLD ticks + 2 after the release. Two of those edges come from the synchronizer.
- R3: `batt_flt_n` follows `batt_ok` with a delay of three edges. While `batt_ok` is low, the block stays in reset hold. A loss of `batt_ok` in any state except fault returns the block to reset hold with all enables low. When the battery comes back, the hold count starts again from its full length.
- R4: `sys_en` rises exactly SYS ticks after `rst_out_n` rises.
- R5: `pwr_en` rises exactly HV ticks after `sys_en` rises, and `sys_en` stays high.
- R6: `pgood` is sampled only once, LV ticks after `pwr_en` rises, and earlier changes of `pgood` have no effect. If it is high at that point, `clk_en` rises at that point and `run` rises one edge later.
- R7: If `pgood` is low when sampled, the block enters a fault state. In the fault state `rst_out_n` is high and `sys_en`, `pwr_en`, `clk_en` and `run` are all low. Changes on `pgood` or `batt_ok` do not move it, and only a new reset request leaves it.
- R8: A reset request in any state clears all enables and drives `rst_out_n` low after the third rising edge. The sequence then restarts with the full hold time.
- R9: `pwr_en` is never high without `sys_en`, `clk_en` is never high without `pwr_en`, and `run` is never high without `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| rst_req_n | input | 1 | Active-low hardware reset request (asynchronous) |
| batt_ok | input | 1 | Battery above set point (asynchronous) |
| pgood | input | 1 | Enabled power domains report OK (asynchronous) |
| rst_out_n | output | 1 | Active-low reset to the processor |
| batt_flt_n | output | 1 | Active-low battery fault; high when input power is present |
| sys_en | output | 1 | High-voltage rail enable |
| pwr_en | output | 1 | Low-voltage rail enable |
| clk_en | output | 1 | Oscillator/PLL enable |
| run | output | 1 | Code execution may begin |

## Verification
The main sequence is run with the four combinations of battery-good and power-good. These runs separate a full bring-up, a latched fault, and a block held in reset. A timed run with good inputs measures each step against its own parameter, so a delay that is swapped or off by one shows up. Further sequences do the following:
- pulse `pgood` low early, which shows that only the final sample counts;
- drop the battery or raise a reset request partway through, which shows the return to hold and the full restart;
- disturb the inputs while in fault, which shows that only a reset request leaves that state.

// File: rtl/pwr_seq.sv
`timescale 1ns/1ps
module pwr_seq #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned HOLD_MS = 50,
  parameter int unsigned SYS_MS  = 10,
  parameter int unsigned HV_MS   = 125,
  parameter int unsigned LV_MS   = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req_n,
  input  logic batt_ok,
  input  logic pgood,
  output logic rst_out_n,
  output logic batt_flt_n,
  output logic sys_en,
  output logic pwr_en,
  output logic clk_en,
  output logic run
);
  localparam logic [63:0] T_HOLD = 64'(HOLD_MS) * 64'(CLK_HZ) / 64'd1000;
  localparam logic [63:0] T_SYS  = 64'(SYS_MS)  * 64'(CLK_HZ) / 64'd1000;
  localparam logic [63:0] T_HV   = 64'(HV_MS)   * 64'(CLK_HZ) / 64'd1000;
  localparam logic [63:0] T_LV   = 64'(LV_MS)   * 64'(CLK_HZ) / 64'd1000;
  localparam logic [63:0] T_A    = (T_HOLD > T_SYS) ? T_HOLD : T_SYS;
  localparam logic [63:0] T_B    = (T_HV > T_LV) ? T_HV : T_LV;
  localparam logic [63:0] T_MAX  = (T_A > T_B) ? T_A : T_B;
  localparam int CW = $clog2(T_MAX) + 1;

  typedef enum logic [2:0] {S_HOLD, S_SYS, S_HV, S_LV, S_RUN, S_FAULT} st_t;

  logic [1:0] req_q, bat_q, pg_q;
  logic req_on, bat_s, pg_s, done, reload;
  st_t st, nxt;
  logic [CW-1:0] cnt, ld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q <= '0;
      bat_q <= '0;
      pg_q  <= '0;
    end else begin
      req_q <= {req_q[0], rst_req_n};
      bat_q <= {bat_q[0], batt_ok};
      pg_q  <= {pg_q[0], pgood};
    end

  assign req_on = !req_q[1];
  assign bat_s  = bat_q[1];
  assign pg_s   = pg_q[1];
  assign done   = (cnt == '0);

  always_comb begin
    nxt = st;
    if (req_on) nxt = S_HOLD;
    else if (!bat_s && st != S_FAULT) nxt = S_HOLD;
    else
      case (st)
        S_HOLD: if (done) nxt = S_SYS;
        S_SYS:  if (done) nxt = S_HV;
        S_HV:   if (done) nxt = S_LV;
        S_LV:   if (done) nxt = pg_s ? S_RUN : S_FAULT;
        default: ;
      endcase
  end

  always_comb
    case (nxt)
      S_HOLD:  ld = CW'(T_HOLD - 64'd1);
      S_SYS:   ld = CW'(T_SYS - 64'd1);
      S_HV:    ld = CW'(T_HV - 64'd1);
      S_LV:    ld = CW'(T_LV - 64'd1);
      default: ld = '0;
    endcase

  assign reload = (nxt != st) || (nxt == S_HOLD && (req_on || !bat_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_HOLD;
      cnt        <= CW'(T_HOLD - 64'd1);
      rst_out_n  <= 1'b0;
      batt_flt_n <= 1'b0;
      sys_en     <= 1'b0;
      pwr_en     <= 1'b0;
      clk_en     <= 1'b0;
      run        <= 1'b0;
    end else begin
      st         <= nxt;
      cnt        <= reload ? ld : (done ? cnt : cnt - 1'b1);
      rst_out_n  <= (nxt != S_HOLD);
      batt_flt_n <= bat_s;
      sys_en     <= (nxt == S_HV) || (nxt == S_LV) || (nxt == S_RUN);
      pwr_en     <= (nxt == S_LV) || (nxt == S_RUN);
      clk_en     <= (nxt == S_RUN);
      run        <= (nxt == S_RUN) && clk_en;
    end

  p_rail_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en |-> sys_en) and (clk_en |-> pwr_en) and (run |-> clk_en));

  p_req_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_on |=> (!rst_out_n && !sys_en && !pwr_en && !clk_en && !run));

  p_batt_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bat_s && st != S_FAULT) |=> (!rst_out_n && !sys_en));

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && !req_on) |=> (st == S_FAULT && !sys_en && !pwr_en && rst_out_n));

  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (!sys_en && !clk_en));
endmodule

// File: tb/sim_pwr_seq.sv
`timescale 1ns/1ps
module sim_pwr_seq;
  localparam int HOLD = 50, SYSD = 10, HV = 125, LV = 125;
  logic clk = 1'b0, rst_n = 1'b0, rst_req_n = 1'b0, batt_ok = 1'b0, pgood = 1'b0;
  logic rst_out_n, batt_flt_n, sys_en, pwr_en, clk_en, run;
  int checks = 0, fails = 0, cyc = 0;
  int t_rst, t_sys, t_pwr, t_clk, t_run;
  logic p_rst = 0, p_sys = 0, p_pwr = 0, p_clk = 0, p_run = 0;

  pwr_seq #(.CLK_HZ(1000), .HOLD_MS(HOLD), .SYS_MS(SYSD), .HV_MS(HV), .LV_MS(LV)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .batt_ok(batt_ok), .pgood(pgood),
    .rst_out_n(rst_out_n), .batt_flt_n(batt_flt_n), .sys_en(sys_en), .pwr_en(pwr_en),
    .clk_en(clk_en), .run(run));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_out_n && !p_rst) t_rst = cyc;
    if (sys_en && !p_sys) t_sys = cyc;
    if (pwr_en && !p_pwr) t_pwr = cyc;
    if (clk_en && !p_clk) t_clk = cyc;
    if (run && !p_run) t_run = cyc;
    p_rst = rst_out_n; p_sys = sys_en; p_pwr = pwr_en; p_clk = clk_en; p_run = run;
  end

  function automatic logic [5:0] outs();
    return {rst_out_n, batt_flt_n, sys_en, pwr_en, clk_en, run};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic b, input logic p);
    @(negedge clk);
    rst_req_n = 1'b0; batt_ok = b; pgood = p;
    cycles(5);
    rst_req_n = 1'b1;
  endtask

  function automatic int edges_to_rst();
    return 0;
  endfunction

  task automatic count_hold(input string req);
    int k = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (rst_out_n) break;
    end
    check(req, k, HOLD + 2);
  endtask

  localparam logic [7:0] VEC [4] = '{
    {1'b1, 1'b1, 6'b111111},
    {1'b1, 1'b0, 6'b110000},
    {1'b0, 1'b1, 6'b000000},
    {1'b0, 1'b0, 6'b000000}
  };

  initial begin
    #1_200_000;
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 reset outputs", int'(outs()), 0);
    rst_n = 1'b1;
    cycles(2);

    for (int v = 0; v < 4; v++) begin
      restart(VEC[v][7], VEC[v][6]);
      cycles(400);
      check($sformatf("R6/R7/R3 vector %0d", v), int'(outs()), int'(VEC[v][5:0]));
    end

    restart(1'b1, 1'b1);
    count_hold("R2 hold length");
    cycles(300);
    check("R4 sys delay", t_sys - t_rst, SYSD);
    check("R5 pwr delay", t_pwr - t_sys, HV);
    check("R6 clk delay", t_clk - t_pwr, LV);
    check("R6 run after clk", t_run - t_clk, 1);

    restart(1'b1, 1'b0);
    wait (sys_en); cycles(20);
    pgood = 1'b1;
    cycles(330);
    check("R6 early pgood ignored", int'(outs()), 6'b111111);

    restart(1'b1, 1'b1);
    wait (sys_en); cycles(20);
    pgood = 1'b0; cycles(20); pgood = 1'b1;
    cycles(330);
    check("R6 early pgood drop ignored", int'(run), 1);

    restart(1'b1, 1'b0);
    cycles(400);
    check("R7 fault entered", int'(outs()), 6'b110000);
    pgood = 1'b1; cycles(50);
    check("R7 pgood ignored in fault", int'(outs()), 6'b110000);
    batt_ok = 1'b0; cycles(10);
    check("R7 battery ignored in fault", int'(outs()), 6'b100000);
    batt_ok = 1'b1; cycles(10);
    check("R7 still fault", int'(outs()), 6'b110000);
    restart(1'b1, 1'b1);
    cycles(400);
    check("R7 reset request exits fault", int'(outs()), 6'b111111);

    restart(1'b1, 1'b1);
    wait (pwr_en); cycles(10);
    rst_req_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 not yet cleared", int'(pwr_en), 1);
    @(posedge clk); @(negedge clk);
    check("R8 cleared after third edge", int'(outs()), 6'b010000);
    cycles(5);
    rst_req_n = 1'b1;
    count_hold("R8 full hold restart");

    restart(1'b1, 1'b1);
    wait (sys_en); cycles(10);
    batt_ok = 1'b0;
    cycles(5);
    check("R3 battery loss returns to hold", int'(outs()), 6'b000000);
    batt_ok = 1'b1;
    count_hold("R3 hold restarts after battery");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule